// File: doc/BRIEF.md
# Free-Running Timer with Compare and Wrap Flags

This block is a 16-bit up-counter that advances by one on each system-clock cycle in which a tick-enable input is high. Two compare registers, A and B, are checked against the count. Each has its own sticky flag. A third sticky flag records the counter rolling over from all ones to zero. The counter never clears itself on a match. It keeps running until software loads a new value.

A compare flag is raised in the last cycle of the matching count, which is the ticked cycle in which the counter is about to leave the compare value. A count that merely rests on the compare value while the tick input is low raises nothing. A small register port lets software load the counter and both compare registers, read every register back, and clear flags by writing zeros. The three flag levels are also brought out as interrupt request lines.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous active-low reset the counter reads 0x0000, both compare registers read 0xFFFF, the flag register reads 0 and all three request outputs are low.
- R2: When the counter is not written, it increases by exactly one (modulo 2^16) in each cycle where `tick` is high, and holds its value when `tick` is low.
- R3: A write to address 0 loads `wdata` into the counter in that cycle, taking priority over any increment. The loaded value reads back on the next cycle.
- R4: A compare flag (bit 0 for A, bit 1 for B) is set on the cycle after one in which the counter equals that compare register, `tick` is high and the counter is not being written. Equality with `tick` low sets nothing.
- R5: A compare match does not alter the counter, which advances past the compare value normally.
- R6: The wrap flag (bit 2) is set on the cycle after a ticked, unwritten cycle in which the counter holds 0xFFFF, and the counter then reads 0x0000.
- R7: A write to address 3 clears every flag whose `wdata` bit is 0 and leaves flags whose bit is 1 unchanged.
- R8: If a flag's set condition and a clearing write to address 3 fall in the same cycle, the flag ends up set.
- R9: A cycle in which the counter is written produces no compare or wrap event, even if the old count equals a compare value, or equals 0xFFFF, and `tick` is high.
- R10: `rdata` shows the register selected by `addr` in the same cycle: 0 counter, 1 compare A, 2 compare B, 3 flags in bits 2:0 with all upper bits zero. Writes to addresses 1 and 2 load the compare registers.
- R11: `irq_cmp_a`, `irq_cmp_b` and `irq_wrap` always equal flag bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq_cmp_a | output | 1 | Level of compare A flag |
| irq_cmp_b | output | 1 | Level of compare B flag |
| irq_wrap | output | 1 | Level of wrap flag |

## Verification
Two kinds of event can land in the same cycle. A flag's set condition can meet a software write that clears it. A ticked cycle on a matching count, or on 0xFFFF, can meet a counter load. The bench provokes both on purpose. It first parks the counter on a compare value and then issues the flag-clear write, or the counter write, together with `tick`. After that it repeats such collisions many times under pseudo-random stimulus with small compare values near the count. A behavioural model settles each cycle, with set taking precedence over clear and a load suppressing every event, and it compares read data and request lines on every clock.

// File: rtl/cmp_timer_pkg.sv
// Shared constants for the compare timer.
// Assumes two compare channels and a four-entry register space.
package cmp_timer_pkg;
    localparam int NUM_CMP = 2;
    localparam int FLAG_W  = NUM_CMP + 1;
    localparam int WRAP_BIT = NUM_CMP;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP_A = 2'd1,
        SEL_CMP_B = 2'd2,
        SEL_FLAGS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cmp_timer_counter.sv
// Free-running up-counter with a software load port.
// Assumes a load takes priority over a tick. It reports whether the count
// steps this cycle and whether that step wraps from all ones to zero.
module cmp_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             step,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // The count advances only when ticked and not overwritten.
    assign step = tick && !load;
    assign wrap = step && (count_q == ALL_ONES);

    // Count register: reset, load, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/cmp_timer_cmp.sv
// One compare channel: a writable compare register and its match detector.
// Assumes the match is the last ticked cycle on the equal count, so it is
// qualified by the counter's step signal.
module cmp_timer_cmp #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    output logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    logic [CNT_W-1:0] cmp_q;

    // Compare register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= RST_VAL;
        end else if (wr) begin
            cmp_q <= wval;
        end
    end

    // Match pulse as the count leaves the compare value.
    assign hit     = step && (count == cmp_q);
    assign cmp_val = cmp_q;
endmodule

// File: rtl/cmp_timer_flags.sv
// Sticky flag bank with clear-by-writing-zero.
// Assumes a set event in the same cycle as a clear leaves the flag set.
module cmp_timer_flags #(
    parameter int FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_ev,
    input  logic              clr_wr,
    input  logic [FLAG_W-1:0] keep_mask,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] kept;

    // Bits written as zero are dropped; all others survive.
    assign kept = clr_wr ? (flags_q & keep_mask) : flags_q;

    // Flag storage, with set given precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= kept | set_ev;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/cmp_timer.sv
// Top level of the free-running compare timer.
// It decodes the register port, builds one compare channel per generate
// iteration and muxes read data. Assumes a single-cycle, always-ready
// register port.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq_cmp_a,
    output logic              irq_cmp_b,
    output logic              irq_wrap
);
    logic [CNT_W-1:0]              cnt_q;
    logic                          cnt_step;
    logic                          cnt_wrap;
    logic                          cnt_wr;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [NUM_CMP-1:0]            cmp_hit;
    logic [NUM_CMP-1:0]            cmp_wr;
    logic [FLAG_W-1:0]             flag_q;
    logic [FLAG_W-1:0]             set_ev;
    logic                          flag_wr;

    // Write decode for counter and flag register.
    assign cnt_wr  = wr_en && (addr == SEL_COUNT);
    assign flag_wr = wr_en && (addr == SEL_FLAGS);

    cmp_timer_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (wdata),
        .count    (cnt_q),
        .step     (cnt_step),
        .wrap     (cnt_wrap)
    );

    for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_cmp
        // Compare channel ch sits at register address ch+1.
        assign cmp_wr[ch] = wr_en && (addr == ADDR_W'(ch + 1));

        cmp_timer_cmp #(.CNT_W(CNT_W), .RST_VAL({CNT_W{1'b1}})) cmp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cmp_wr[ch]),
            .wval    (wdata),
            .count   (cnt_q),
            .step    (cnt_step),
            .cmp_val (cmp_q[ch]),
            .hit     (cmp_hit[ch])
        );
    end

    // Flag set sources: compare channels low, wrap on top.
    assign set_ev = {cnt_wrap, cmp_hit};

    cmp_timer_flags #(.FLAG_W(FLAG_W)) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (set_ev),
        .clr_wr    (flag_wr),
        .keep_mask (wdata[FLAG_W-1:0]),
        .flags     (flag_q)
    );

    // Read data mux.
    always_comb begin
        unique case (addr)
            SEL_COUNT: rdata = cnt_q;
            SEL_CMP_A: rdata = cmp_q[0];
            SEL_CMP_B: rdata = cmp_q[1];
            default:   rdata = CNT_W'(flag_q);
        endcase
    end

    assign irq_cmp_a = flag_q[0];
    assign irq_cmp_b = flag_q[1];
    assign irq_wrap  = flag_q[WRAP_BIT];
endmodule

// File: rtl/cmp_timer_chk.sv
// Property checker for the compare timer, attached by bind.
// Assumes the top's internal count, compare and flag registers are visible.
module cmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b,
    input logic [2:0]       flags,
    input logic             irq_a,
    input logic             irq_b,
    input logic             irq_w
);
    logic ld;
    assign ld = wr_en && (addr == 2'd0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(wdata)));

    assert_cmp_a_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt == cmp_a) |=> flags[0]);

    assert_cmp_b_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt == cmp_b) |=> flags[1]);

    assert_wrap_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt == {CNT_W{1'b1}}) |=> (flags[2] && cnt == '0));

    assert_no_event_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !($rose(flags[0]) || $rose(flags[1]) || $rose(flags[2])));

    assert_irq_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a == flags[0]) && (irq_b == flags[1]) && (irq_w == flags[2]));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cnt   (cnt_q),
    .cmp_a (cmp_q[0]),
    .cmp_b (cmp_q[1]),
    .flags (flag_q),
    .irq_a (irq_cmp_a),
    .irq_b (irq_cmp_b),
    .irq_w (irq_wrap)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_cmp_a, irq_cmp_b, irq_wrap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_cnt = '0;
    logic [15:0] m_cmp [2] = '{16'hFFFF, 16'hFFFF};
    logic [2:0]  m_flags = '0;

    always #2 clk = ~clk;

    cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_cmp_a(irq_cmp_a),
        .irq_cmp_b(irq_cmp_b), .irq_wrap(irq_wrap)
    );

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_cmp[0];
            2'd2: return m_cmp[1];
            default: return {13'b0, m_flags};
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance the model by one clock with the given inputs.
    task automatic model_step(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
        bit ld;
        logic [2:0] ev;
        ld = w && (a == 2'd0);
        ev = '0;
        if (t && !ld) begin
            if (m_cnt == m_cmp[0]) ev[0] = 1'b1;
            if (m_cnt == m_cmp[1]) ev[1] = 1'b1;
            if (m_cnt == 16'hFFFF) ev[2] = 1'b1;
        end
        if (w && a == 2'd3) m_flags = m_flags & d[2:0];
        m_flags = m_flags | ev;
        if (w && a == 2'd1) m_cmp[0] = d;
        if (w && a == 2'd2) m_cmp[1] = d;
        if (ld) m_cnt = d;
        else if (t) m_cnt = m_cnt + 16'd1;
    endtask

    // One cycle: drive, clock, then compare outputs against the model.
    task automatic cyc(input logic t, input logic w, input logic [1:0] a,
                       input logic [15:0] d, input string req);
        tick = t; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_step(t, w, a, d);
        @(negedge clk);
        check(req, rdata, m_read(a));
        check({req, "/R11"}, {13'b0, irq_wrap, irq_cmp_b, irq_cmp_a}, {13'b0, m_flags});
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        cyc(1'b0, 1'b0, a, 16'h0, req);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string req);
        cyc(1'b0, 1'b1, a, d, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, "R1"); check("R1 count", rdata, 16'h0000);
        rd(2'd1, "R1"); check("R1 cmpA", rdata, 16'hFFFF);
        rd(2'd2, "R1"); check("R1 cmpB", rdata, 16'hFFFF);
        rd(2'd3, "R1"); check("R1 flags", rdata, 16'h0000);

        // R2 ticks with gaps
        for (int i = 0; i < 6; i++) cyc(i[0], 1'b0, 2'd0, 16'h0, "R2");
        check("R2 count", rdata, 16'h0003);

        // R10 compare writes and readback
        wr(2'd1, 16'h0010, "R10"); rd(2'd1, "R10"); check("R10 cmpA", rdata, 16'h0010);
        wr(2'd2, 16'h0012, "R10"); rd(2'd2, "R10"); check("R10 cmpB", rdata, 16'h0012);

        // R3 load while ticking
        cyc(1'b1, 1'b1, 2'd0, 16'h000E, "R3"); check("R3 load", rdata, 16'h000E);
        cyc(1'b1, 1'b0, 2'd0, 16'h0, "R2");
        cyc(1'b1, 1'b0, 2'd0, 16'h0, "R2"); check("R2 at match", rdata, 16'h0010);
        // R4 resting on the compare value without tick: no flag
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 2'd3, 16'h0, "R4");
        check("R4 idle equal", rdata, 16'h0000);
        cyc(1'b1, 1'b0, 2'd3, 16'h0, "R4");
        check("R4 flag A", {15'b0, irq_cmp_a}, 16'h0001);
        // R5 counter runs through the match
        rd(2'd0, "R5"); check("R5 past match", rdata, 16'h0011);
        cyc(1'b1, 1'b0, 2'd0, 16'h0, "R5");
        // R8 set B with simultaneous clear-all write
        cyc(1'b1, 1'b1, 2'd3, 16'h0000, "R8");
        check("R8 set wins", rdata, 16'h0002);
        // R7 writing ones keeps, zero clears
        wr(2'd3, 16'hFFFF, "R7"); check("R7 keep", rdata, 16'h0002);
        wr(2'd3, 16'hFFFD, "R7"); check("R7 clear", rdata, 16'h0000);

        // R9 load on a matching ticked cycle gives no event
        wr(2'd0, 16'h0010, "R9");
        cyc(1'b1, 1'b1, 2'd0, 16'hFFFF, "R9");
        rd(2'd3, "R9"); check("R9 no flag", rdata, 16'h0000);
        cyc(1'b1, 1'b1, 2'd0, 16'h0005, "R9");
        rd(2'd3, "R9"); check("R9 no wrap", rdata, 16'h0000);

        // R6 wrap
        wr(2'd0, 16'hFFFD, "R6");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 2'd0, 16'h0, "R6");
        check("R6 count zero", rdata, 16'h0000);
        rd(2'd3, "R6"); check("R6 wrap flag", rdata, 16'h0004);
        wr(2'd3, 16'h0000, "R7");

        // pseudo-random collisions
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            d = lf[15] ? (16'hFFF0 | {12'h0, lf[11:8]}) : {12'h0, lf[11:8]};
            if (lf[6:5] == 2'd3) d = {13'h1FFF, lf[9:7]};
            cyc(lf[0] | lf[1], lf[4:2] == 3'd0, lf[6:5], d, "R4/R8/R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule